// File: doc/BRIEF.md
# Inter-Core Mailbox with Per-Slot Interrupt Flags

This block lets two processors on one chip pass short messages to each other through a small register file on an APB bus. There are two directions. The outbound direction carries messages from the system core to the calculation core. The return direction carries messages back. Each direction has four slots. A slot holds a command word, a data word and a full flag. Storing a command word into a slot sets that slot's flag. The flag then interrupts the core on the other side. The receiving core reads the words and writes a one to the matching bit of the clear register, which empties the slot.

Each flag drives its own interrupt line. The outbound flags drive the four calculation-core lines and the return flags drive the four system-core lines. An enable bit per line masks the interrupt without touching the flag, so software can poll a masked slot. Bus transfers are handled by a two-state protocol machine. PH_IDLE moves to PH_ACCESS when a setup phase is seen (select high, enable low). PH_ACCESS always returns to PH_IDLE after one cycle, with PREADY high during it. Writes take effect at the end of PH_ACCESS.

Register layout: direction d (0 = outbound, 1 = return) and slot n have their command word at offset d*0x40 + n*8 and their data word at that offset + 4. The flag status register is at 0x80, the clear register at 0x84 and the enable register at 0x88. In all three, bit n is outbound slot n and bit 4+n is return slot n.

Top module: `xcore_mailbox`

## Requirements
- R1: After reset (asynchronous, active low) every flag, enable bit, command word and data word is zero, both interrupt buses are zero and reads of 0x80 and 0x88 return zero. Reset also clears state set before it.
- R2: A write to a command offset (d*0x40 + n*8) stores the word and sets flag n of direction d. A write to the data offset (command offset + 4) stores the word and leaves the flag unchanged. Both words read back at their offsets.
- R3: Outbound flag n (status bit n) drives irq_calc[n], and return flag n (status bit 4+n) drives irq_sys[n]. Each line follows its flag in the cycle after the flag is written, provided its enable bit is one.
- R4: Enable register 0x88 (bit n gates irq_calc[n], bit 4+n gates irq_sys[n]) masks an interrupt line. Masking leaves the flag unchanged, and the flag stays visible in status register 0x80.
- R5: Writing clear register 0x84 clears every flag whose bit is one and leaves flags whose bit is zero unchanged. Reading 0x84 returns zero.
- R6: Setting a flag has priority over clearing it. A command write to a slot that is already full keeps the flag and its interrupt set and replaces the stored command.
- R7: An access to any offset that is not mapped completes with PSLVERR high. A read of such an offset returns zero, and a write to it changes no flag, enable bit or interrupt.
- R8: Each transfer takes a setup cycle (PH_IDLE) and one access cycle (PH_ACCESS) with PREADY high. PREADY is low in the setup cycle and never high on two cycles in a row. PSLVERR is low for mapped offsets.
- R9: Status register 0x80 is read-only. A write to it is accepted without error and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while pready is high |
| pready | output | 1 | Transfer completes this cycle |
| pslverr | output | 1 | Unmapped offset accessed |
| irq_sys | output | 4 | Interrupts to the system core, one per return slot |
| irq_calc | output | 4 | Interrupts to the calculation core, one per outbound slot |

## Verification
The embedded properties check the following on every cycle. A flag may rise only after a command write. A flag may fall only after a clear that had no command write in the same cycle. A command write always leaves the flag set. PREADY is never high two cycles in a row. A write to an unmapped offset leaves the flags and enables as they were. Other behaviour can only be shown by the bench's scenarios: the word values that read back, the fact that a masked line still shows its flag, and the status layout after a mix of sets and clears in both directions. Zero-valued reads at unmapped or write-only offsets, and a reset that wipes a pending interrupt, are also left to the bench.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [0:0] {
        PH_IDLE   = 1'b0,
        PH_ACCESS = 1'b1
    } apb_ph_e;

    localparam int DIR_STRIDE  = 'h40;
    localparam int SLOT_STRIDE = 8;
    localparam int DATA_OFS    = 4;
    localparam int OFS_FLAGS   = 'h80;
    localparam int OFS_CLEAR   = 'h84;
    localparam int OFS_ENABLE  = 'h88;

endpackage

// File: rtl/mbx_apb_fsm.sv
module mbx_apb_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic pready,
    output logic wr_stb,
    output logic rd_act
);

    apb_ph_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (psel && !penable) state_d = PH_ACCESS;
            PH_ACCESS: state_d = PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        pready = 1'b0;
        wr_stb = 1'b0;
        rd_act = 1'b0;
        unique case (state_q)
            PH_IDLE: ;
            PH_ACCESS: begin
                pready = 1'b1;
                wr_stb = psel && penable && pwrite;
                rd_act = psel && penable && !pwrite;
            end
            default: ;
        endcase
    end

    // R8: access phase lasts exactly one cycle
    a_r8_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        pready |=> !pready);

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              data_we,
    input  logic              clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] data_q,
    output logic              flag_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (cmd_we)  cmd_q  <= wdata;
            if (data_we) data_q <= wdata;
            if (cmd_we)   flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
        end
    end

    // R2: a flag only rises after a command write
    a_r2_rise_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(cmd_we));
    // R5: a flag only falls after a clear without a competing command
    a_r5_fall_needs_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(clr && !cmd_we));
    // R6: a command write always leaves the slot full
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> flag_q);

endmodule

// File: rtl/mbx_irq_mask.sv
module mbx_irq_mask #(
    parameter int N = 4
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] en,
    output logic [N-1:0] irq
);

    for (genvar i = 0; i < N; i++) begin : g_line
        assign irq[i] = flags[i] & en[i];
    end

endmodule

// File: rtl/xcore_mailbox.sv
module xcore_mailbox
    import mbx_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [SLOTS-1:0]  irq_sys,
    output logic [SLOTS-1:0]  irq_calc
);

    localparam int NDIR  = 2;
    localparam int FLAGW = NDIR * SLOTS;

    logic              wr_stb, rd_act;
    logic [DATA_W-1:0] cmd_q  [NDIR][SLOTS];
    logic [DATA_W-1:0] data_q [NDIR][SLOTS];
    logic [FLAGW-1:0]  flag_vec;
    logic [FLAGW-1:0]  en_q;
    logic [FLAGW-1:0]  clr_vec;
    logic              hit_flags, hit_clear, hit_enable;
    logic [DATA_W-1:0] rd_mux;
    logic              unmapped;

    mbx_apb_fsm u_fsm (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .pready  (pready),
        .wr_stb  (wr_stb),
        .rd_act  (rd_act)
    );

    assign hit_flags  = (paddr == ADDR_W'(OFS_FLAGS));
    assign hit_clear  = (paddr == ADDR_W'(OFS_CLEAR));
    assign hit_enable = (paddr == ADDR_W'(OFS_ENABLE));
    assign clr_vec    = (wr_stb && hit_clear) ? pwdata[FLAGW-1:0] : '0;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        for (genvar n = 0; n < SLOTS; n++) begin : g_slot
            localparam int CMD_OFS = d * DIR_STRIDE + n * SLOT_STRIDE;
            logic cmd_hit, data_hit;
            assign cmd_hit  = (paddr == ADDR_W'(CMD_OFS));
            assign data_hit = (paddr == ADDR_W'(CMD_OFS + DATA_OFS));
            mbx_slot #(.DATA_W(DATA_W)) u_slot (
                .clk     (pclk),
                .rst_n   (presetn),
                .cmd_we  (wr_stb && cmd_hit),
                .data_we (wr_stb && data_hit),
                .clr     (clr_vec[d*SLOTS+n]),
                .wdata   (pwdata),
                .cmd_q   (cmd_q[d][n]),
                .data_q  (data_q[d][n]),
                .flag_q  (flag_vec[d*SLOTS+n])
            );
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn)                en_q <= '0;
        else if (wr_stb && hit_enable) en_q <= pwdata[FLAGW-1:0];
    end

    always_comb begin
        rd_mux   = '0;
        unmapped = 1'b1;
        if (hit_flags) begin
            rd_mux[FLAGW-1:0] = flag_vec;
            unmapped = 1'b0;
        end
        if (hit_enable) begin
            rd_mux[FLAGW-1:0] = en_q;
            unmapped = 1'b0;
        end
        if (hit_clear) unmapped = 1'b0;
        for (int d = 0; d < NDIR; d++) begin
            for (int n = 0; n < SLOTS; n++) begin
                if (paddr == ADDR_W'(d * DIR_STRIDE + n * SLOT_STRIDE)) begin
                    rd_mux   = cmd_q[d][n];
                    unmapped = 1'b0;
                end
                if (paddr == ADDR_W'(d * DIR_STRIDE + n * SLOT_STRIDE + DATA_OFS)) begin
                    rd_mux   = data_q[d][n];
                    unmapped = 1'b0;
                end
            end
        end
    end

    assign prdata  = (rd_act && !unmapped) ? rd_mux : '0;
    assign pslverr = pready && unmapped;

    mbx_irq_mask #(.N(SLOTS)) u_mask_calc (
        .flags (flag_vec[SLOTS-1:0]),
        .en    (en_q[SLOTS-1:0]),
        .irq   (irq_calc)
    );

    mbx_irq_mask #(.N(SLOTS)) u_mask_sys (
        .flags (flag_vec[FLAGW-1:SLOTS]),
        .en    (en_q[FLAGW-1:SLOTS]),
        .irq   (irq_sys)
    );

    // R7: writes to unmapped offsets leave flags and enables alone
    a_r7_unmapped_no_effect: assert property (@(posedge pclk) disable iff (!presetn)
        (pslverr && pwrite) |=> ($stable(flag_vec) && $stable(en_q)));

    // R9: writing the status offset changes no flag
    a_r9_status_readonly: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_stb && hit_flags) |=> $stable(flag_vec));

endmodule

// File: tb/sim_xcore_mailbox.sv
module sim_xcore_mailbox;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [3:0]  irq_sys, irq_calc;

    int n_chk = 0;
    int n_bad = 0;

    always #2 pclk = ~pclk;

    xcore_mailbox u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_sys(irq_sys), .irq_calc(irq_calc)
    );

    // {wr, addr, wdata, exp_rdata, exp_err, exp_irq_calc, exp_irq_sys}
    localparam int NV = 24;
    localparam logic [81:0] VEC [NV] = '{
        {1'b1, 8'h88, 32'h0000_00FF, 32'h0, 1'b0, 4'b0000, 4'b0000}, // R4 enable all
        {1'b1, 8'h00, 32'h0000_00A5, 32'h0, 1'b0, 4'b0001, 4'b0000}, // R2 R3 cmd out0
        {1'b1, 8'h04, 32'h0000_1234, 32'h0, 1'b0, 4'b0001, 4'b0000}, // R2 data no flag
        {1'b0, 8'h00, 32'h0, 32'h0000_00A5, 1'b0, 4'b0001, 4'b0000}, // R2 readback
        {1'b0, 8'h04, 32'h0, 32'h0000_1234, 1'b0, 4'b0001, 4'b0000}, // R2 readback
        {1'b1, 8'h5C, 32'h0000_BEEF, 32'h0, 1'b0, 4'b0001, 4'b0000}, // R2 return3 data
        {1'b1, 8'h58, 32'h0000_0077, 32'h0, 1'b0, 4'b0001, 4'b1000}, // R3 return3 cmd
        {1'b0, 8'h80, 32'h0, 32'h0000_0081, 1'b0, 4'b0001, 4'b1000}, // R3 status
        {1'b1, 8'h88, 32'h0000_00FE, 32'h0, 1'b0, 4'b0000, 4'b1000}, // R4 mask out0
        {1'b0, 8'h80, 32'h0, 32'h0000_0081, 1'b0, 4'b0000, 4'b1000}, // R4 flag kept
        {1'b0, 8'h88, 32'h0, 32'h0000_00FE, 1'b0, 4'b0000, 4'b1000}, // R4 readback
        {1'b1, 8'h84, 32'h0000_0001, 32'h0, 1'b0, 4'b0000, 4'b1000}, // R5 clear out0
        {1'b0, 8'h84, 32'h0, 32'h0000_0000, 1'b0, 4'b0000, 4'b1000}, // R5 reads zero
        {1'b1, 8'h10, 32'h0000_0005, 32'h0, 1'b0, 4'b0100, 4'b1000}, // R3 out2 cmd
        {1'b1, 8'h10, 32'h0000_0006, 32'h0, 1'b0, 4'b0100, 4'b1000}, // R6 refill full slot
        {1'b0, 8'h10, 32'h0, 32'h0000_0006, 1'b0, 4'b0100, 4'b1000}, // R6 cmd replaced
        {1'b0, 8'h30, 32'h0, 32'h0000_0000, 1'b1, 4'b0100, 4'b1000}, // R7 unmapped read
        {1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0, 1'b1, 4'b0100, 4'b1000}, // R7 unmapped write
        {1'b0, 8'h8C, 32'h0, 32'h0000_0000, 1'b1, 4'b0100, 4'b1000}, // R7 past end
        {1'b1, 8'h80, 32'h0000_00FF, 32'h0, 1'b0, 4'b0100, 4'b1000}, // R9 write status
        {1'b0, 8'h80, 32'h0, 32'h0000_0084, 1'b0, 4'b0100, 4'b1000}, // R9 unchanged
        {1'b1, 8'h84, 32'h0000_0000, 32'h0, 1'b0, 4'b0100, 4'b1000}, // R5 zero bits keep
        {1'b1, 8'h84, 32'h0000_00FF, 32'h0, 1'b0, 4'b0000, 4'b0000}, // R5 clear all
        {1'b0, 8'h80, 32'h0, 32'h0000_0000, 1'b0, 4'b0000, 4'b0000}  // R5 all empty
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] rd_val;
    logic        rd_err, setup_rdy, acc_rdy;

    task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        #1 setup_rdy = pready;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        acc_rdy = pready;
        rd_val  = prdata;
        rd_err  = pslverr;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        check("R1 irq_calc in reset", {28'h0, irq_calc}, 32'h0);
        check("R1 irq_sys in reset", {28'h0, irq_sys}, 32'h0);
        repeat (3) @(posedge pclk);
        @(negedge pclk) presetn = 1'b1;

        apb(1'b0, 8'h80, 32'h0); check("R1 status after reset", rd_val, 32'h0);
        check("R8 ready low in setup", {31'h0, setup_rdy}, 32'h0);
        check("R8 ready high in access", {31'h0, acc_rdy}, 32'h1);
        apb(1'b0, 8'h88, 32'h0); check("R1 enable after reset", rd_val, 32'h0);
        apb(1'b0, 8'h58, 32'h0); check("R1 command after reset", rd_val, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [81:0] v;
            v = VEC[i];
            apb(v[81], v[80:73], v[72:41]);
            if (!v[81]) check($sformatf("R2/R7 read vec %0d", i), rd_val, v[40:9]);
            check($sformatf("R7/R8 pslverr vec %0d", i), {31'h0, rd_err}, {31'h0, v[8]});
            check($sformatf("R3/R4 irq_calc vec %0d", i), {28'h0, irq_calc}, {28'h0, v[7:4]});
            check($sformatf("R3/R4 irq_sys vec %0d", i), {28'h0, irq_sys}, {28'h0, v[3:0]});
        end

        // R1: reset wipes a pending interrupt
        apb(1'b1, 8'h88, 32'hFF);
        apb(1'b1, 8'h48, 32'h9);
        check("R3 return1 irq before reset", {28'h0, irq_sys}, 32'h2);
        @(negedge pclk) presetn = 1'b0;
        #1 check("R1 irq_sys cleared by reset", {28'h0, irq_sys}, 32'h0);
        @(negedge pclk) presetn = 1'b1;
        apb(1'b0, 8'h80, 32'h0); check("R1 status after mid reset", rd_val, 32'h0);
        apb(1'b0, 8'h48, 32'h0); check("R1 command after mid reset", rd_val, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule